// File: doc/BRIEF.md
# Oversampled UART Receive Recovery

This block is the receive front end of an asynchronous serial port. It samples the receive line on every pulse of a time base that runs at sixteen times the baud rate. While the line is idle it waits for a high-to-low transition. It then confirms the start bit and recovers one start bit, eight data bits (least significant bit first) and one stop bit. A data or stop bit takes the value that at least two of its three mid-bit samples agree on.

The recovered byte goes to an output register, and a receive-data-full flag is raised with it. A noise flag reports mid-bit samples that disagree. A framing flag reports a stop bit that resolves to zero, which includes a break character. A single clear strobe drops all three flags. Baud generation, parity, overrun detection and register access belong to the surrounding port logic.

Top module: `uart_rx_recover`

## Requirements
- R1: After the asynchronous reset, `data_o` is 0x00 and `rdrf_o`, `nf_o` and `fe_o` are all low.
- R2: A frame starts only when a low line sample follows at least three consecutive high samples. That low sample is sample position 1 of the start bit. Each bit lasts 16 samples, and bits are judged at sample positions 8, 9 and 10 of each bit, counted from that edge.
- R3: The start bit is confirmed from its samples at positions 3, 5 and 7. If fewer than two of them are low, the receiver drops the frame, reports nothing and returns to the idle search.
- R4: Each of the eight data bits takes the majority value of its samples at positions 8, 9 and 10. The first data bit after the start bit lands in `data_o[0]`.
- R5: If the three judged samples of any data bit or of the stop bit are not all equal, `nf_o` is set. The bit still takes the majority value, and bit timing carries on unchanged.
- R6: The samples at positions 8, 9 and 10 of the start bit play no part in noise detection.
- R7: If the stop bit's majority value is low, `fe_o` is set. A break (start, data and stop bits all low) therefore yields `data_o` = 0x00 with `fe_o` set.
- R8: `data_o`, `rdrf_o`, `nf_o` and `fe_o` all take their new values on the same clock edge: the edge on which the stop bit's position-10 tick is taken.
- R9: `nf_o` and `fe_o` stay set across later frames until `clr_i` is asserted. When no frame completes in that cycle, `clr_i` clears `rdrf_o`, `nf_o` and `fe_o` on the next edge.
- R10: `data_o` changes only when a frame completes. A clear leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at 16x the baud rate |
| rxd_i | input | 1 | Serial receive line, idle high |
| clr_i | input | 1 | Clears the full, noise and framing flags |
| data_o | output | 8 | Last received byte |
| rdrf_o | output | 1 | Receive data full |
| nf_o | output | 1 | Noise seen in a data or stop bit |
| fe_o | output | 1 | Stop bit resolved as zero |

## Verification
The properties assume that `tick_i` is a single-cycle pulse and that `rxd_i` holds steady long enough to pass through the input synchroniser before the tick that samples it. The stimulus changes the line only on a clock falling edge, and it does so several clocks before each tick. Noise and timing faults are therefore injected as whole altered samples, never as sub-tick glitches. The stimulus raises the clear strobe only well away from the completion of a frame, so the clear property can be checked against the port values alone.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_vote.sv
module uart_rx_vote (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic maj_o,
  output logic split_o
);
  assign maj_o   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign split_o = (a_i | b_i | c_i) & ~(a_i & b_i & c_i);
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_RUN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rxd_i,
  input  logic hist_clr_i,
  output logic samp_o,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [IDLE_RUN-1:0]    hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= SYNC_STAGES'({sync_q, rxd_i});
  end

  assign samp_o = sync_q[SYNC_STAGES-1];

  // run of recent high samples; cleared whenever a frame ends or is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (tick_i) begin
      if (hist_clr_i)    hist_q <= '0;
      else               hist_q <= IDLE_RUN'({hist_q, samp_o});
    end
  end

  assign edge_o = tick_i & ~samp_o & (&hist_q);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 samp_i,
  input  logic                 edge_i,
  output logic                 hist_clr_o,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 noise_o,
  output logic                 ferr_o
);
  localparam int RTW = $clog2(OSR);
  localparam int BCW = $clog2(DATA_BITS);
  // indices hold sample position minus one
  localparam logic [RTW-1:0] IX_V1  = RTW'(OSR/2 - 1);
  localparam logic [RTW-1:0] IX_V2  = RTW'(OSR/2);
  localparam logic [RTW-1:0] IX_V3  = RTW'(OSR/2 + 1);
  localparam logic [RTW-1:0] IX_S1  = RTW'(OSR/2 - 6);
  localparam logic [RTW-1:0] IX_S2  = RTW'(OSR/2 - 4);
  localparam logic [RTW-1:0] IX_S3  = RTW'(OSR/2 - 2);
  localparam logic [RTW-1:0] IX_END = RTW'(OSR - 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_BITS - 1);

  rx_state_e            state_q;
  logic [RTW-1:0]       rt_q, rt_cur;
  logic [BCW-1:0]       bit_q;
  logic                 cap_a_q, cap_b_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 noise_q;
  logic                 maj, split, reject;

  uart_rx_vote u_vote (
    .a_i    (cap_a_q),
    .b_i    (cap_b_q),
    .c_i    (samp_i),
    .maj_o  (maj),
    .split_o(split)
  );

  assign rt_cur = (rt_q == IX_END) ? '0 : rt_q + 1'b1;

  // start check: majority high at position 7 means the start bit was false
  assign reject     = tick_i && (state_q == RX_START) && (rt_cur == IX_S3) && maj;
  assign done_o     = tick_i && (state_q == RX_STOP) && (rt_cur == IX_V3);
  assign hist_clr_o = done_o | reject;
  assign byte_o     = shreg_q;
  assign noise_o    = noise_q | split;
  assign ferr_o     = ~maj;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      rt_q    <= '0;
      bit_q   <= '0;
      cap_a_q <= 1'b1;
      cap_b_q <= 1'b1;
      shreg_q <= '0;
      noise_q <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        RX_IDLE: begin
          if (edge_i) begin
            state_q <= RX_START;
            rt_q    <= '0;
          end
        end
        RX_START: begin
          rt_q <= rt_cur;
          if (rt_cur == IX_S1) cap_a_q <= samp_i;
          if (rt_cur == IX_S2) cap_b_q <= samp_i;
          if (reject) state_q <= RX_IDLE;
          else if (rt_cur == IX_END) begin
            state_q <= RX_DATA;
            bit_q   <= '0;
            noise_q <= 1'b0;
          end
        end
        RX_DATA: begin
          rt_q <= rt_cur;
          if (rt_cur == IX_V1) cap_a_q <= samp_i;
          if (rt_cur == IX_V2) cap_b_q <= samp_i;
          if (rt_cur == IX_V3) begin
            shreg_q <= DATA_BITS'({maj, shreg_q} >> 1);
            noise_q <= noise_q | split;
          end
          if (rt_cur == IX_END) begin
            if (bit_q == LAST_BIT) state_q <= RX_STOP;
            else                   bit_q   <= bit_q + 1'b1;
          end
        end
        RX_STOP: begin
          rt_q <= rt_cur;
          if (rt_cur == IX_V1) cap_a_q <= samp_i;
          if (rt_cur == IX_V2) cap_b_q <= samp_i;
          if (done_o) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover #(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_RUN    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  input  logic                 clr_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 rdrf_o,
  output logic                 nf_o,
  output logic                 fe_o
);
  logic                 samp, edge_det, hist_clr;
  logic                 frame_done, frame_noise, frame_ferr;
  logic [DATA_BITS-1:0] frame_byte;

  uart_rx_sampler #(
    .SYNC_STAGES(SYNC_STAGES),
    .IDLE_RUN   (IDLE_RUN)
  ) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rxd_i     (rxd_i),
    .hist_clr_i(hist_clr),
    .samp_o    (samp),
    .edge_o    (edge_det)
  );

  uart_rx_frame #(
    .OSR      (OSR),
    .DATA_BITS(DATA_BITS)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .samp_i    (samp),
    .edge_i    (edge_det),
    .hist_clr_o(hist_clr),
    .done_o    (frame_done),
    .byte_o    (frame_byte),
    .noise_o   (frame_noise),
    .ferr_o    (frame_ferr)
  );

  // completion has priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      rdrf_o <= 1'b0;
      nf_o   <= 1'b0;
      fe_o   <= 1'b0;
    end else if (frame_done) begin
      data_o <= frame_byte;
      rdrf_o <= 1'b1;
      nf_o   <= (nf_o & ~clr_i) | frame_noise;
      fe_o   <= (fe_o & ~clr_i) | frame_ferr;
    end else if (clr_i) begin
      rdrf_o <= 1'b0;
      nf_o   <= 1'b0;
      fe_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_recover_chk.sv
module uart_rx_recover_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 clr_i,
  input logic                 done_i,
  input logic [DATA_BITS-1:0] data_i,
  input logic                 rdrf_i,
  input logic                 nf_i,
  input logic                 fe_i
);
  // R8
  rdrf_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdrf_i) |-> $past(tick_i));

  // R8
  fe_with_rdrf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fe_i) |-> rdrf_i);

  // R8
  done_sets_rdrf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> rdrf_i);

  // R9
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_i) |=> (!rdrf_i && !nf_i && !fe_i));

  // R9
  nf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nf_i && !clr_i) |=> nf_i);

  // R9
  fe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_i && !clr_i) |=> fe_i);

  // R10
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_i));
endmodule

bind uart_rx_recover uart_rx_recover_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tick_i(tick_i),
  .clr_i (clr_i),
  .done_i(frame_done),
  .data_i(data_o),
  .rdrf_i(rdrf_o),
  .nf_i  (nf_o),
  .fe_i  (fe_o)
);

// File: tb/tb_uart_rx_recover.sv
`timescale 1ns/1ps
module tb_uart_rx_recover;
  logic       clk_i = 1'b0;
  logic       rst_ni, tick_i, rxd_i, clr_i;
  logic [7:0] data_o;
  logic       rdrf_o, nf_o, fe_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] d;
    logic       nf;
    logic       fe;
    bit         clr;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;

  uart_rx_recover dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .rxd_i (rxd_i),
    .clr_i (clr_i),
    .data_o(data_o),
    .rdrf_o(rdrf_o),
    .nf_o  (nf_o),
    .fe_o  (fe_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_with(input logic v);
    @(negedge clk_i);
    rxd_i = v;
    repeat (2) @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic send_ticks(input logic v, input int n);
    for (int i = 0; i < n; i++) tick_with(v);
  endtask

  // fbit: 0 start, 1..8 data, 9 stop; fmask inverts samples at positions (bit index + 1)
  task automatic send_frame(input logic [7:0] d, input logic stop_v,
                            input int fbit, input logic [15:0] fmask);
    for (int b = 0; b < 10; b++) begin
      logic val;
      val = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
      for (int rt = 0; rt < 16; rt++) tick_with(val ^ ((b == fbit) && fmask[rt]));
    end
  endtask

  task automatic expect_frame(input logic [7:0] d, input logic nf, input logic fe,
                              input bit clr, input string tag);
    exp_t e;
    e.d = d; e.nf = nf; e.fe = fe; e.clr = clr; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: a completed frame shows as rdrf rising or a new byte while full
  initial begin
    logic       rdrf_prev;
    logic [7:0] data_prev;
    rdrf_prev = 1'b0;
    data_prev = 8'h00;
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i);
      if (rdrf_o && (!rdrf_prev || data_o != data_prev)) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected frame", 8'h01, 8'h00);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({"R4 data ", e.tag}, data_o, e.d);
          chk({"R5 nf ", e.tag}, {7'd0, nf_o}, {7'd0, e.nf});
          chk({"R7 fe ", e.tag}, {7'd0, fe_o}, {7'd0, e.fe});
          chk({"R8 rdrf ", e.tag}, {7'd0, rdrf_o}, 8'h01);
          if (e.clr) begin
            clr_i = 1'b1;
            @(negedge clk_i);
            clr_i = 1'b0;
            chk({"R9 cleared ", e.tag}, {5'd0, rdrf_o, nf_o, fe_o}, 8'h00);
            chk({"R10 data kept ", e.tag}, data_o, e.d);
          end
        end
      end
      rdrf_prev = rdrf_o;
      data_prev = data_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    tick_i = 1'b0;
    rxd_i  = 1'b1;
    clr_i  = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 data", data_o, 8'h00);
    chk("R1 flags", {5'd0, rdrf_o, nf_o, fe_o}, 8'h00);

    send_ticks(1'b1, 4);

    expect_frame(8'hA5, 1'b0, 1'b0, 1, "clean A5");
    send_frame(8'hA5, 1'b1, -1, 16'h0);
    send_ticks(1'b1, 2);

    // R5 one sample flipped at position 9 of data bit 2
    expect_frame(8'h3C, 1'b1, 1'b0, 1, "noisy data");
    send_frame(8'h3C, 1'b1, 3, 16'h0100);
    send_ticks(1'b1, 2);

    // R6 start bit sample at position 8 flipped: no noise
    expect_frame(8'h5A, 1'b0, 1'b0, 1, "start noise ignored R6");
    send_frame(8'h5A, 1'b1, 0, 16'h0080);
    send_ticks(1'b1, 2);

    // R2 data bit 2 correct only at positions 8..10
    expect_frame(8'hC3, 1'b0, 1'b0, 1, "alignment R2");
    send_frame(8'hC3, 1'b1, 3, 16'hFC7F);
    send_ticks(1'b1, 2);

    // R3 short low pulse: start dropped, no frame reported
    send_ticks(1'b0, 2);
    send_ticks(1'b1, 14);
    expect_frame(8'h96, 1'b0, 1'b0, 1, "after false start R3");
    send_frame(8'h96, 1'b1, -1, 16'h0);
    send_ticks(1'b1, 2);

    // R5 stop bit with one low sample at position 10
    expect_frame(8'h81, 1'b1, 1'b0, 1, "noisy stop");
    send_frame(8'h81, 1'b1, 9, 16'h0200);
    send_ticks(1'b1, 2);

    // R7 stop bit low
    expect_frame(8'h7E, 1'b0, 1'b1, 1, "low stop R7");
    send_frame(8'h7E, 1'b0, -1, 16'h0);
    send_ticks(1'b1, 4);

    // R7 break, then R2: two high samples do not arm the start search
    expect_frame(8'h00, 1'b0, 1'b1, 1, "break R7");
    send_frame(8'h00, 1'b0, -1, 16'h0);
    send_ticks(1'b0, 20);
    send_ticks(1'b1, 2);
    send_ticks(1'b0, 3);
    send_ticks(1'b1, 4);
    expect_frame(8'h69, 1'b0, 1'b0, 1, "after short idle R2");
    send_frame(8'h69, 1'b1, -1, 16'h0);
    send_ticks(1'b1, 2);

    // R9 noise flag survives a clean frame without a clear
    expect_frame(8'h12, 1'b1, 1'b0, 0, "sticky first");
    send_frame(8'h12, 1'b1, 1, 16'h0080);
    send_ticks(1'b1, 2);
    expect_frame(8'h34, 1'b1, 1'b0, 1, "sticky R9");
    send_frame(8'h34, 1'b1, -1, 16'h0);
    send_ticks(1'b1, 2);

    // R7 and R5 stop bit with two low samples
    expect_frame(8'hFF, 1'b1, 1'b1, 1, "split stop low");
    send_frame(8'hFF, 1'b1, 9, 16'h0180);
    send_ticks(1'b1, 2);

    expect_frame(8'h00, 1'b0, 1'b0, 1, "clean 00");
    send_frame(8'h00, 1'b1, -1, 16'h0);
    send_ticks(1'b1, 10);

    chk("R3 all expected frames seen", 8'(exp_q.size()), 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule